// File: doc/BRIEF.md
# Low-Frequency Alarm Timer

This block keeps time from a slow, free-running 32.768 kHz reference. It counts rising edges of that reference into a 32-bit current-time counter and compares the count against a programmable 32-bit alarm value. The slow reference enters through a synchronizer into the host clock domain. Each detected rising edge becomes a one-cycle tick there, so the counter, the alarm logic and the register file all run on the host clock. The alarm output is a transient event. It is raised on the tick at which the count reaches the alarm value, and it falls on the next tick. When auto-reset is on, the counter returns to zero at every match, so an alarm value of N gives a wake event every N ticks.

Software reaches the block through four word registers: control/status, count holding register, alarm value and fail limit. The counter cannot be read or written directly. A capture strobe copies the whole count into the holding register in one cycle, so the value read back is coherent. A load strobe copies the holding register into the counter. A watchdog on the host clock counts cycles between ticks. It raises a sticky oscillator-fail flag when the number of quiet cycles reaches the programmed limit, and any control write clears that flag.

Top module: `lf_alarm_timer`

## Requirements
- R1: After reset the control/status word reads 0, the holding register reads 0, the alarm register reads 0xFFFFFFFF, the fail limit reads the FAIL_LIMIT_RST parameter, and both alarm_o and osc_fail_o are low.
- R2: The reference is synchronized through two host-clock flops. While the run bit (control bit 0) is 1, each rising edge of lf_clk_i increments the counter by one. The increment lands three host-clock edges after the first edge that samples the reference high. While run is 0 the count does not change.
- R3: With alarm-enable (control bit 1) set, alarm_o and status bit 5 rise on the tick at which the incremented count equals the alarm register. They fall on the next tick that does not match, so an isolated alarm lasts exactly one reference period.
- R4: With auto-reset (control bit 2) set, a matching tick loads zero into the counter instead of the alarm value, so an alarm value of N gives one alarm every N reference periods.
- R5: While run is 1, osc_fail_o and status bit 6 are set once the host-clock cycles since the last tick reach a nonzero fail limit (address 3, low 16 bits). The flag then stays set until any write to the control register.
- R6: A control write with alarm-enable 0 clears the alarm flag at that edge. While alarm-enable is 0, no alarm is raised.
- R7: A control write with bit 3 set copies the present count into the holding register (address 1). The holding register changes only on a capture or a direct write to it.
- R8: A control write with bit 4 set loads the holding register into the counter. That tick's increment and alarm update are skipped.
- R9: Register map: address 0 control/status, address 1 holding register, address 2 alarm value, address 3 fail limit. Written values read back combinationally, and bits 3 and 4 of the control word always read 0.
- R10: The counter wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lf_clk_i | input | 1 | Slow 32.768 kHz reference, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| alarm_o | output | 1 | Alarm event, high for one reference period |
| osc_fail_o | output | 1 | Sticky oscillator-fail flag |

## Verification
The bench goes after the length of the alarm pulse. A design that made the flag sticky would hold alarm_o high for many periods, and one that cleared it after one host cycle would be almost invisible. Auto-reset is checked by counting exactly one alarm per N periods; an off-by-one match would stretch the period to N+1. The same-edge priority of load over tick is exercised, as is the coherence of the holding register while the counter keeps running, and wrap-around at the top of the count. Stopping the reference checks that the fail flag sets, survives until a control write and does not set while the reference runs.

// File: rtl/lfat_pkg.sv
package lfat_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_HOLD  = 2'd1,
    ADDR_ALARM = 2'd2,
    ADDR_LIMIT = 2'd3
  } lfat_addr_e;

  localparam int unsigned CTRL_RUN   = 0;
  localparam int unsigned CTRL_AEN   = 1;
  localparam int unsigned CTRL_AUTO  = 2;
  localparam int unsigned CTRL_CAP   = 3;
  localparam int unsigned CTRL_LOAD  = 4;
  localparam int unsigned STAT_ALARM = 5;
  localparam int unsigned STAT_FAIL  = 6;

  typedef struct packed {
    logic auto_rst;
    logic alarm_en;
    logic run;
  } lfat_ctrl_t;
endpackage

// File: rtl/lfat_edge_sync.sv
module lfat_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned W = STAGES + 1;

  logic [W-1:0] pipe_q;

  // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its previous value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[W-2:0], async_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  p_tick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/lfat_time_core.sv
module lfat_time_core
  import lfat_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  lfat_ctrl_t       ctrl_i,
  input  logic             load_i,
  input  logic             cap_i,
  input  logic             clr_i,
  input  logic             hold_wr_i,
  input  logic             alarm_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] hold_o,
  output logic [CNT_W-1:0] alarm_val_o,
  output logic             alarm_o
);
  logic [CNT_W-1:0] count_q, hold_q, alarm_q, cnt_nxt;
  logic             flag_q, match, step;

  assign cnt_nxt = count_q + 1'b1;
  assign match   = ctrl_i.alarm_en && (cnt_nxt == alarm_q);
  assign step    = tick_i && ctrl_i.run && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= hold_q;
    else if (step)   count_q <= (match && ctrl_i.auto_rst) ? '0 : cnt_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (step)  flag_q <= match;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= '0;
    else if (hold_wr_i) hold_q <= wdata_i;
    else if (cap_i)     hold_q <= count_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         alarm_q <= '1;
    else if (alarm_wr_i) alarm_q <= wdata_i;
  end

  assign hold_o      = hold_q;
  assign alarm_val_o = alarm_q;
  assign alarm_o     = flag_q;

  p_alarm_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i));
  p_auto_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_q) && $past(ctrl_i.auto_rst)) |-> (count_q == '0));
  p_clear_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_q);
  p_count_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(count_q));
  p_hold_coherent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_wr_i && !cap_i) |=> $stable(hold_q));
endmodule

// File: rtl/lfat_fail_watch.sv
module lfat_fail_watch #(
  parameter int unsigned          LIMIT_W   = 16,
  parameter logic [LIMIT_W-1:0]   LIMIT_RST = 16'd1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               restart_i,
  input  logic               limit_wr_i,
  input  logic [LIMIT_W-1:0] limit_wdata_i,
  output logic [LIMIT_W-1:0] limit_o,
  output logic               fail_o
);
  logic [LIMIT_W-1:0] miss_q, limit_q;
  logic               fail_q, quiet_full;

  assign quiet_full = run_i && !tick_i && (limit_q != '0) && (miss_q == limit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            miss_q <= '0;
    else if (!run_i || tick_i || restart_i) miss_q <= '0;
    else if (miss_q != limit_q)             miss_q <= miss_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fail_q <= 1'b0;
    else if (restart_i)  fail_q <= 1'b0;
    else if (quiet_full) fail_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         limit_q <= LIMIT_RST;
    else if (limit_wr_i) limit_q <= limit_wdata_i;
  end

  assign limit_o = limit_q;
  assign fail_o  = fail_q;

  p_fail_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !restart_i) |=> fail_q);
  p_fail_needs_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> ($past(run_i) && !$past(tick_i)));
endmodule

// File: rtl/lf_alarm_timer.sv
module lf_alarm_timer
  import lfat_pkg::*;
#(
  parameter int unsigned        DATA_W         = 32,
  parameter int unsigned        LIMIT_W        = 16,
  parameter int unsigned        SYNC_STAGES    = 2,
  parameter logic [LIMIT_W-1:0] FAIL_LIMIT_RST = 16'd1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lf_clk_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              alarm_o,
  output logic              osc_fail_o
);
  localparam int unsigned PAD_W = DATA_W - LIMIT_W;

  lfat_ctrl_t        ctrl_q;
  lfat_addr_e        addr;
  logic              tick, ctrl_wr, hold_wr, alarm_wr, limit_wr;
  logic              alarm_flag, fail_flag;
  logic [DATA_W-1:0] hold_val, alarm_val, stat_word;
  logic [LIMIT_W-1:0] limit_val;
  logic              unused_wdata;

  assign addr     = lfat_addr_e'(reg_addr_i);
  assign ctrl_wr  = reg_we_i && (addr == ADDR_CTRL);
  assign hold_wr  = reg_we_i && (addr == ADDR_HOLD);
  assign alarm_wr = reg_we_i && (addr == ADDR_ALARM);
  assign limit_wr = reg_we_i && (addr == ADDR_LIMIT);
  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_wr) begin
      ctrl_q.run      <= reg_wdata_i[CTRL_RUN];
      ctrl_q.alarm_en <= reg_wdata_i[CTRL_AEN];
      ctrl_q.auto_rst <= reg_wdata_i[CTRL_AUTO];
    end
  end

  lfat_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(lf_clk_i),
    .rise_o (tick)
  );

  lfat_time_core #(.CNT_W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .ctrl_i     (ctrl_q),
    .load_i     (ctrl_wr && reg_wdata_i[CTRL_LOAD]),
    .cap_i      (ctrl_wr && reg_wdata_i[CTRL_CAP]),
    .clr_i      (ctrl_wr && !reg_wdata_i[CTRL_AEN]),
    .hold_wr_i  (hold_wr),
    .alarm_wr_i (alarm_wr),
    .wdata_i    (reg_wdata_i),
    .hold_o     (hold_val),
    .alarm_val_o(alarm_val),
    .alarm_o    (alarm_flag)
  );

  lfat_fail_watch #(.LIMIT_W(LIMIT_W), .LIMIT_RST(FAIL_LIMIT_RST)) u_watch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .run_i        (ctrl_q.run),
    .restart_i    (ctrl_wr),
    .limit_wr_i   (limit_wr),
    .limit_wdata_i(reg_wdata_i[LIMIT_W-1:0]),
    .limit_o      (limit_val),
    .fail_o       (fail_flag)
  );

  always_comb begin
    stat_word             = '0;
    stat_word[CTRL_RUN]   = ctrl_q.run;
    stat_word[CTRL_AEN]   = ctrl_q.alarm_en;
    stat_word[CTRL_AUTO]  = ctrl_q.auto_rst;
    stat_word[STAT_ALARM] = alarm_flag;
    stat_word[STAT_FAIL]  = fail_flag;
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL:  reg_rdata_o = stat_word;
      ADDR_HOLD:  reg_rdata_o = hold_val;
      ADDR_ALARM: reg_rdata_o = alarm_val;
      default:    reg_rdata_o = {{PAD_W{1'b0}}, limit_val};
    endcase
  end

  assign alarm_o    = alarm_flag;
  assign osc_fail_o = fail_flag;

  p_no_alarm_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.alarm_en && !alarm_o) |=> !alarm_o);
  p_status_mirror_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == ADDR_CTRL) |-> (reg_rdata_o[STAT_FAIL] == osc_fail_o));
endmodule

// File: tb/sim_lf_alarm_timer.sv
module sim_lf_alarm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lf = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        alarm, ofail;

  int checks = 0;
  int fails  = 0;
  bit lf_en  = 1'b1;
  int lf_ph  = 0;

  always #10 clk = ~clk;

  lf_alarm_timer #(.FAIL_LIMIT_RST(16'd40)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lf_clk_i(lf), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .alarm_o(alarm), .osc_fail_o(ofail)
  );

  // reference: period 8 host cycles
  always @(negedge clk) if (lf_en) begin
    lf_ph = lf_ph + 1;
    if (lf_ph == 4) begin lf_ph = 0; lf = ~lf; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model
  logic [31:0] m_cnt, m_hold, m_alarm;
  logic [15:0] m_limit, m_miss;
  bit m_run, m_aen, m_auto, m_af, m_fail;
  bit h0, h1, h2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_alarm = '1; m_limit = 16'd40; m_miss = 0;
      m_run = 0; m_aen = 0; m_auto = 0; m_af = 0; m_fail = 0;
      h0 = 0; h1 = 0; h2 = 0;
    end else begin
      bit tk, cw, ld, mt;
      logic [31:0] nx, n_cnt, n_hold;
      bit n_af, n_fail;
      logic [15:0] n_miss;
      tk = h1 && !h2;
      cw = we && addr == 2'd0;
      ld = cw && wd[4];
      nx = m_cnt + 1;
      mt = m_aen && (nx == m_alarm);
      n_cnt = m_cnt;
      if (ld) n_cnt = m_hold;
      else if (tk && m_run) n_cnt = (mt && m_auto) ? 32'd0 : nx;
      n_af = m_af;
      if (cw && !wd[1]) n_af = 0;
      else if (tk && m_run && !ld) n_af = mt;
      n_hold = m_hold;
      if (we && addr == 2'd1) n_hold = wd;
      else if (cw && wd[3]) n_hold = m_cnt;
      n_miss = m_miss;
      if (!m_run || tk || cw) n_miss = 0;
      else if (m_miss != m_limit) n_miss = m_miss + 1;
      n_fail = m_fail;
      if (cw) n_fail = 0;
      else if (m_run && !tk && m_limit != 0 && m_miss == m_limit) n_fail = 1;
      if (we && addr == 2'd2) m_alarm = wd;
      if (we && addr == 2'd3) m_limit = wd[15:0];
      if (cw) begin m_run = wd[0]; m_aen = wd[1]; m_auto = wd[2]; end
      m_cnt = n_cnt; m_hold = n_hold; m_af = n_af; m_miss = n_miss; m_fail = n_fail;
      h2 = h1; h1 = h0; h0 = lf;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: exp_rd = {25'd0, m_fail, m_af, 2'b00, m_auto, m_aen, m_run};
      2'd1: exp_rd = m_hold;
      2'd2: exp_rd = m_alarm;
      default: exp_rd = {16'd0, m_limit};
    endcase
  endfunction

  // every-cycle comparison
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk(alarm == m_af, "R3 alarm_o", {31'd0, alarm}, {31'd0, m_af});
      chk(ofail == m_fail, "R5 osc_fail_o", {31'd0, ofail}, {31'd0, m_fail});
      chk(rdata == exp_rd(addr), "R9 reg_rdata_o", rdata, exp_rd(addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wd = d;
    @(negedge clk); we = 1'b0; wd = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(posedge clk); #5; d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int highs, rises;
    bit prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 hold", v, 0);
    rd(2'd2, v); chk(v == 32'hFFFF_FFFF, "R1 alarm", v, 32'hFFFF_FFFF);
    rd(2'd3, v); chk(v == 40, "R1 limit", v, 40);
    chk(!alarm && !ofail, "R1 outputs", {30'd0, alarm, ofail}, 0);
    // R9 readback
    wr(2'd2, 32'hA5A5_0F0F); rd(2'd2, v); chk(v == 32'hA5A5_0F0F, "R9 alarm rb", v, 32'hA5A5_0F0F);
    wr(2'd3, 32'hFFFF_0014); rd(2'd3, v); chk(v == 32'h14, "R9 limit rb", v, 32'h14);
    wr(2'd0, 32'h1F); rd(2'd0, v); chk(v[4:0] == 5'h07, "R9 strobes read 0", v, 7);
    wr(2'd0, 32'h0);
    // R2 run off holds count
    wait_cyc(40);
    wr(2'd0, 32'h8); rd(2'd1, v); chk(v == 0, "R2 stopped", v, 0);
    // R2 counting
    wr(2'd0, 32'h1); wait_cyc(80);
    wr(2'd0, 32'h9); rd(2'd1, v);
    chk(v >= 9 && v <= 11, "R2 count advance", v, 10);
    chk(v == m_hold, "R2 model", v, m_hold);
    // R7 holding coherent
    wait_cyc(40); rd(2'd1, v2); chk(v2 == v, "R7 hold stable", v2, v);
    // R8 load
    wr(2'd1, 32'h1234); wr(2'd0, 32'h11); wr(2'd0, 32'h9); rd(2'd1, v);
    chk(v >= 32'h1234 && v <= 32'h1235, "R8 load", v, 32'h1234);
    // R3 single alarm
    wr(2'd1, 0); wr(2'd2, 5); wr(2'd0, 32'h13);
    highs = 0; rises = 0; prev = 0;
    repeat (120) begin @(posedge clk); #5; if (alarm) highs++; if (alarm && !prev) rises++; prev = alarm; end
    chk(highs == 8, "R3 pulse width", highs, 8);
    chk(rises == 1, "R3 one event", rises, 1);
    // R4 auto-reset period 3
    wr(2'd2, 3); wr(2'd1, 0); wr(2'd0, 32'h17);
    wait_cyc(30);
    rises = 0; prev = alarm;
    repeat (240) begin @(posedge clk); #5; if (alarm && !prev) rises++; prev = alarm; end
    chk(rises == 10, "R4 period N", rises, 10);
    wr(2'd0, 32'hF); rd(2'd1, v); chk(v < 3, "R4 count bounded", v, 0);
    // R6 clear by alarm-enable low
    while (!alarm) @(negedge clk);
    wr(2'd0, 32'h5); #5; chk(!alarm, "R6 cleared", {31'd0, alarm}, 0);
    rises = 0;
    repeat (100) begin @(posedge clk); #5; if (alarm) rises++; end
    chk(rises == 0, "R6 no alarm when disabled", rises, 0);
    // R10 wrap
    wr(2'd1, 32'hFFFF_FFFE); wr(2'd0, 32'h11); wait_cyc(40);
    wr(2'd0, 32'h9); rd(2'd1, v);
    chk(v < 8, "R10 wrap", v, 3);
    // R5 oscillator fail
    wr(2'd0, 32'h1); wait_cyc(100);
    chk(!ofail, "R5 no fail running", {31'd0, ofail}, 0);
    lf_en = 0; wait_cyc(60);
    chk(ofail, "R5 fail set", {31'd0, ofail}, 1);
    lf_en = 1; wait_cyc(50);
    chk(ofail, "R5 sticky", {31'd0, ofail}, 1);
    rd(2'd0, v); chk(v[6], "R5 status bit", v, 32'h41);
    wr(2'd0, 32'h1); #5;
    chk(!ofail, "R5 cleared by write", {31'd0, ofail}, 0);
    wait_cyc(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule